// File: doc/BRIEF.md
# Strap-Oriented Two-Port Crossbar Controller

This block connects two host-side ports to two line-side ports through a 2x2 crossbar. An orientation strap pin sets which host port reaches which line port. The strap is read only once per reset cycle, after a fixed start-up sequence. When the active-low external reset releases, the block first holds an internal reset phase of `RST_CYC` clocks. It then waits `DLY_CYC` clocks, which by default is one millisecond at `CLK_HZ`. At the end of that wait it captures the synchronized strap and keeps it until the external reset is asserted again.

Each port pair carries traffic in both directions. Each direction has a data field and a valid bit, and both directions are steered by the same latched select. A status output reports that the orientation has been captured. Until then every crossbar output stays at its idle value, so no traffic passes while the strap is still settling. A board ties the strap high or low. Any later movement of the pin while the block runs leaves the routing unchanged.

Top module: `strap_xbar_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until `orient_ok_o` rises, `orient_ok_o` is 0 and every crossbar output is idle: all valid outputs 0 and all data outputs equal to `IDLE_DATA` (default all zeros).
- R2: `orient_ok_o` rises on exactly the (`RST_CYC`+`DLY_CYC`)-th rising clock edge at which `rst_n` is high, counted from the release.
- R3: The strap passes through a synchronizer of `SYNC_STAGES` flops (default 2) before capture. With the default, the captured value is the strap level present at the rising edge two edges before the one that raises `orient_ok_o`.
- R4: With a captured strap of 0, the forward path routes h0 to line A and h1 to line B, and the reverse path routes line A to h0 and line B to h1. Data and valid travel together, combinationally, in the same cycle.
- R5: With a captured strap of 1, the forward path routes h0 to line B and h1 to line A, and the reverse path routes line B to h0 and line A to h1. Data and valid travel together, combinationally, in the same cycle.
- R6: Once `orient_ok_o` is 1, strap changes have no effect on routing until the next reset.
- R7: Driving `rst_n` low at any time, including partway through the start-up sequence, clears `orient_ok_o` at once and idles all outputs. The next release restarts the full sequence and captures a fresh strap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| strap_i | input | 1 | Orientation strap (asynchronous) |
| h0_fwd_data_i | input | DATA_W | Host port 0 outbound data |
| h0_fwd_vld_i | input | 1 | Host port 0 outbound valid |
| h1_fwd_data_i | input | DATA_W | Host port 1 outbound data |
| h1_fwd_vld_i | input | 1 | Host port 1 outbound valid |
| la_fwd_data_o | output | DATA_W | Line port A outbound data |
| la_fwd_vld_o | output | 1 | Line port A outbound valid |
| lb_fwd_data_o | output | DATA_W | Line port B outbound data |
| lb_fwd_vld_o | output | 1 | Line port B outbound valid |
| la_rev_data_i | input | DATA_W | Line port A inbound data |
| la_rev_vld_i | input | 1 | Line port A inbound valid |
| lb_rev_data_i | input | DATA_W | Line port B inbound data |
| lb_rev_vld_i | input | 1 | Line port B inbound valid |
| h0_rev_data_o | output | DATA_W | Host port 0 inbound data |
| h0_rev_vld_o | output | 1 | Host port 0 inbound valid |
| h1_rev_data_o | output | DATA_W | Host port 1 inbound data |
| h1_rev_vld_o | output | 1 | Host port 1 inbound valid |
| orient_ok_o | output | 1 | Orientation captured and routing enabled |

## Verification
The assertions assume that `rst_n` leaves reset cleanly with respect to the clock. They also assume the strap is stable across the synchronizer window before capture, so that a single level is captured. The bench releases reset only on falling clock edges. Strap changes are placed at falling edges, either well away from the capture window or at one chosen edge around it. This pins down which value a two-stage synchronizer must hand over. Data inputs are randomized freely, because routing has no constraint on them.

// File: rtl/strap_xbar_pkg.sv
package strap_xbar_pkg;

   typedef enum logic [1:0] {
      SEQ_IRST = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_st_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("strap_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      if (STAGES == 2) begin : g_pair
         logic s0_q, s1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s0_q <= 1'b0;
               s1_q <= 1'b0;
            end else begin
               s0_q <= d_i;
               s1_q <= s0_q;
            end
         end
         assign q_o = s1_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d_i};
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/strap_seq.sv
module strap_seq
   import strap_xbar_pkg::*;
#(
   parameter int unsigned RST_CYC = 32,
   parameter int unsigned DLY_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_s_i,
   output logic orient_o,
   output logic ok_o
);

   localparam int unsigned MAXC  = max2(RST_CYC, DLY_CYC);
   localparam int unsigned CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MAXC - 1);

   generate
      if (RST_CYC < 1) begin : g_bad_rst
         $error("strap_seq: RST_CYC must be at least 1");
      end
      if (DLY_CYC < 1) begin : g_bad_dly
         $error("strap_seq: DLY_CYC must be at least 1");
      end
   endgenerate

   seq_st_e          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             orient_q;
   logic             ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IRST;
         cnt_q    <= '0;
         orient_q <= 1'b0;
         ok_q     <= 1'b0;
      end else begin
         unique case (st_q)
            SEQ_IRST: begin
               if (cnt_q == RST_LAST) begin
                  st_q  <= SEQ_WAIT;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_WAIT: begin
               if (cnt_q == DLY_LAST) begin
                  st_q     <= SEQ_RUN;
                  cnt_q    <= '0;
                  orient_q <= strap_s_i;
                  ok_q     <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_RUN: begin
               cnt_q <= '0;
            end
            default: begin
               st_q  <= SEQ_IRST;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign orient_o = orient_q;
   assign ok_o     = ok_q;

   // R2
   ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_q) |-> ($past(st_q) == SEQ_WAIT) && ($past(cnt_q) == DLY_LAST));

   // R6
   orient_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |=> $stable(orient_q));

   // R7
   ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |=> ok_q);

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_TOP);

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_q) |-> orient_q == $past(strap_s_i));

endmodule

// File: rtl/xbar_lane.sv
module xbar_lane #(
   parameter int unsigned          W         = 16,
   parameter logic [W-1:0]         IDLE_DATA = '0
) (
   input  logic                en_i,
   input  logic                sel_i,
   input  logic [1:0][W-1:0]   src_data_i,
   input  logic [1:0]          src_vld_i,
   output logic [1:0][W-1:0]   dst_data_o,
   output logic [1:0]          dst_vld_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("xbar_lane: W must be at least 1");
      end
   endgenerate

   for (genvar j = 0; j < 2; j++) begin : g_dst
      logic pick;
      assign pick = sel_i ^ j[0];
      always_comb begin
         if (!en_i) begin
            dst_data_o[j] = IDLE_DATA;
            dst_vld_o[j]  = 1'b0;
         end else begin
            dst_data_o[j] = src_data_i[pick];
            dst_vld_o[j]  = src_vld_i[pick];
         end
      end
   end

endmodule

// File: rtl/strap_xbar_ctrl.sv
module strap_xbar_ctrl
   import strap_xbar_pkg::*;
#(
   parameter int unsigned        DATA_W      = 16,
   parameter int unsigned        CLK_HZ      = 100_000_000,
   parameter int unsigned        RST_CYC     = 32,
   parameter int unsigned        DLY_CYC     = CLK_HZ / 1000,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0]  IDLE_DATA   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_i,
   input  logic [DATA_W-1:0] h0_fwd_data_i,
   input  logic              h0_fwd_vld_i,
   input  logic [DATA_W-1:0] h1_fwd_data_i,
   input  logic              h1_fwd_vld_i,
   output logic [DATA_W-1:0] la_fwd_data_o,
   output logic              la_fwd_vld_o,
   output logic [DATA_W-1:0] lb_fwd_data_o,
   output logic              lb_fwd_vld_o,
   input  logic [DATA_W-1:0] la_rev_data_i,
   input  logic              la_rev_vld_i,
   input  logic [DATA_W-1:0] lb_rev_data_i,
   input  logic              lb_rev_vld_i,
   output logic [DATA_W-1:0] h0_rev_data_o,
   output logic              h0_rev_vld_o,
   output logic [DATA_W-1:0] h1_rev_data_o,
   output logic              h1_rev_vld_o,
   output logic              orient_ok_o
);

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("strap_xbar_ctrl: DATA_W must be at least 1");
      end
      if (CLK_HZ < 1000) begin : g_bad_hz
         $error("strap_xbar_ctrl: CLK_HZ must be at least 1000");
      end
   endgenerate

   logic strap_s;
   logic orient;
   logic ok;

   strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (strap_i),
      .q_o   (strap_s)
   );

   strap_seq #(.RST_CYC(RST_CYC), .DLY_CYC(DLY_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_s_i (strap_s),
      .orient_o  (orient),
      .ok_o      (ok)
   );

   logic [1:0][DATA_W-1:0] fwd_src_d, fwd_dst_d, rev_src_d, rev_dst_d;
   logic [1:0]             fwd_src_v, fwd_dst_v, rev_src_v, rev_dst_v;

   assign fwd_src_d = {h1_fwd_data_i, h0_fwd_data_i};
   assign fwd_src_v = {h1_fwd_vld_i,  h0_fwd_vld_i};
   assign rev_src_d = {lb_rev_data_i, la_rev_data_i};
   assign rev_src_v = {lb_rev_vld_i,  la_rev_vld_i};

   xbar_lane #(.W(DATA_W), .IDLE_DATA(IDLE_DATA)) u_fwd (
      .en_i       (ok),
      .sel_i      (orient),
      .src_data_i (fwd_src_d),
      .src_vld_i  (fwd_src_v),
      .dst_data_o (fwd_dst_d),
      .dst_vld_o  (fwd_dst_v)
   );

   xbar_lane #(.W(DATA_W), .IDLE_DATA(IDLE_DATA)) u_rev (
      .en_i       (ok),
      .sel_i      (orient),
      .src_data_i (rev_src_d),
      .src_vld_i  (rev_src_v),
      .dst_data_o (rev_dst_d),
      .dst_vld_o  (rev_dst_v)
   );

   assign la_fwd_data_o = fwd_dst_d[0];
   assign la_fwd_vld_o  = fwd_dst_v[0];
   assign lb_fwd_data_o = fwd_dst_d[1];
   assign lb_fwd_vld_o  = fwd_dst_v[1];
   assign h0_rev_data_o = rev_dst_d[0];
   assign h0_rev_vld_o  = rev_dst_v[0];
   assign h1_rev_data_o = rev_dst_d[1];
   assign h1_rev_vld_o  = rev_dst_v[1];
   assign orient_ok_o   = ok;

   // R1
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !orient_ok_o |-> !la_fwd_vld_o && !lb_fwd_vld_o && !h0_rev_vld_o && !h1_rev_vld_o
                       && la_fwd_data_o == IDLE_DATA && lb_fwd_data_o == IDLE_DATA
                       && h0_rev_data_o == IDLE_DATA && h1_rev_data_o == IDLE_DATA);

   // R4
   straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (orient_ok_o && !orient) |-> la_fwd_data_o == h0_fwd_data_i && lb_fwd_vld_o == h1_fwd_vld_i
                                   && h0_rev_data_o == la_rev_data_i && h1_rev_vld_o == lb_rev_vld_i);

   // R5
   cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (orient_ok_o && orient) |-> la_fwd_data_o == h1_fwd_data_i && lb_fwd_vld_o == h0_fwd_vld_i
                                  && h0_rev_data_o == lb_rev_data_i && h1_rev_vld_o == la_rev_vld_i);

endmodule

// File: tb/test_strap_xbar_ctrl.sv
module test_strap_xbar_ctrl;

   localparam int unsigned DW = 8;
   localparam int unsigned RC = 5;
   localparam int unsigned DC = 20;
   localparam int          N  = RC + DC;
   localparam int          OW = 4 * (DW + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap = 1'b0;
   logic [DW-1:0] h0_d, h1_d, la_d, lb_d;
   logic          h0_v, h1_v, la_v, lb_v;
   logic [DW-1:0] la_o_d, lb_o_d, h0_o_d, h1_o_d;
   logic          la_o_v, lb_o_v, h0_o_v, h1_o_v, ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   strap_xbar_ctrl #(
      .DATA_W(DW), .CLK_HZ(20000), .RST_CYC(RC), .DLY_CYC(DC), .SYNC_STAGES(2)
   ) i_strap_xbar_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_i(strap),
      .h0_fwd_data_i(h0_d), .h0_fwd_vld_i(h0_v),
      .h1_fwd_data_i(h1_d), .h1_fwd_vld_i(h1_v),
      .la_fwd_data_o(la_o_d), .la_fwd_vld_o(la_o_v),
      .lb_fwd_data_o(lb_o_d), .lb_fwd_vld_o(lb_o_v),
      .la_rev_data_i(la_d), .la_rev_vld_i(la_v),
      .lb_rev_data_i(lb_d), .lb_rev_vld_i(lb_v),
      .h0_rev_data_o(h0_o_d), .h0_rev_vld_o(h0_o_v),
      .h1_rev_data_o(h1_o_d), .h1_rev_vld_o(h1_o_v),
      .orient_ok_o(ok)
   );

   function automatic logic [OW-1:0] exp_out(input bit en, input bit ori);
      if (!en) return '0;
      if (!ori) return {h0_d, h0_v, h1_d, h1_v, la_d, la_v, lb_d, lb_v};
      return {h1_d, h1_v, h0_d, h0_v, lb_d, lb_v, la_d, la_v};
   endfunction

   task automatic check(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive_rand();
      h0_d = DW'($urandom); h1_d = DW'($urandom);
      la_d = DW'($urandom); lb_d = DW'($urandom);
      {h0_v, h1_v, la_v, lb_v} = 4'($urandom);
   endtask

   task automatic check_route(input bit en, input bit ori, input string req);
      logic [OW-1:0] act, exp;
      act = {la_o_d, la_o_v, lb_o_d, lb_o_v, h0_o_d, h0_o_v, h1_o_d, h1_o_v};
      exp = exp_out(en, ori);
      check(act === exp, req, 64'(act), 64'(exp));
      check(ok === en, req, 64'(ok), 64'(en));
   endtask

   task automatic hold_reset(input bit s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      drive_rand();
      #1;
      check_route(1'b0, 1'b0, "R7 reset idles outputs");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // run a sequence; strap flips to !s at negedge after edge flip_at (0 = never)
   task automatic run_seq(input bit s, input int flip_at, input bit ori, input string req);
      hold_reset(s);
      for (int k = 1; k <= N; k++) begin
         @(posedge clk);
         @(negedge clk);
         drive_rand();
         if (k == flip_at) strap = ~s;
         if (k == flip_at + 1 && flip_at > 0 && flip_at == N - 3) strap = s;
         #1;
         if (k < N) check_route(1'b0, ori, "R1 idle before capture");
         else       check_route(1'b1, ori, req);
      end
   endtask

   task automatic run_traffic(input bit ori, input int cycles, input string req);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         drive_rand();
         strap = 1'($urandom);
         #1;
         check_route(1'b1, ori, req);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      drive_rand();
      #1;
      // R1 reset state
      check_route(1'b0, 1'b0, "R1 reset state");

      // R2 R4 straight orientation, exact rise cycle
      run_seq(1'b0, 0, 1'b0, "R2 R4 capture strap 0");
      // R6 strap changes ignored while running
      run_traffic(1'b0, 40, "R6 R4 strap ignored");

      // R5 crossed orientation
      run_seq(1'b1, 0, 1'b1, "R2 R5 capture strap 1");
      run_traffic(1'b1, 40, "R6 R5 strap ignored");

      // R3 value at edge N-2 reaches capture (pulse 0->1->0 around window)
      run_seq(1'b0, N - 3, 1'b1, "R3 sync window pulse captured");
      // R3 change after edge N-2 is too late for capture
      run_seq(1'b1, N - 2, 1'b1, "R3 late change not captured");
      // R3 change during delay well before window is taken
      run_seq(1'b0, 5, 1'b1, "R3 early change captured");

      // R7 reset partway through the sequence, then full restart
      hold_reset(1'b1);
      repeat (10) @(negedge clk);
      run_seq(1'b1, 0, 1'b1, "R7 R2 restart after mid reset");
      run_traffic(1'b1, 10, "R7 R5 after restart");
      run_seq(1'b0, 0, 1'b0, "R7 R4 fresh capture after run reset");
      run_traffic(1'b0, 10, "R7 R4 after second reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule